// File: doc/BRIEF.md
# Nibble Accumulator ALU Datapath

This block is the arithmetic and logic core of a small accumulator processor. It holds a W-bit accumulator and a two-bit flags register (carry and equal). Every operation combines the accumulator, as operand A, with the word currently on the data bus, as operand B. A three-bit operation code, a carry-in bit and two load enables all arrive from the control store each cycle. The flags feed a sequencer, which uses them to pick branches.

The carry-in is always a control-store bit. The stored carry flag never reaches the adder. Software that chains additions across nibbles tests the carry flag and adds the extra one itself. A compare is a subtract with carry-in forced high and the accumulator load left off, so only the flags change. The ALU result also leaves the block on a bus drive output with its own enable, which is how results reach memory or an output port.

Top module: `nib_alu_dp`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the carry flag and the equal flag by the first clock edge that samples reset high.
- R2: With op_sel = 1 (add), the result is the low W bits of A + B + alu_cin. The carry flag takes the carry out of the top bit.
- R3: With op_sel = 2 (subtract/compare), the result is A + ~B + alu_cin. With alu_cin = 1 this is A - B, the carry flag is 1 exactly when A >= B, and the equal flag is 1 exactly when A == B.
- R4: The stored carry flag has no effect on any result. Only the alu_cin input enters the adder.
- R5: op_sel = 3, 4, 5 and 6 give A AND B, A OR B, A XOR B and NOT A. op_sel = 0 passes B. All of these produce a carry of 0.
- R6: While acc_ld is low the accumulator holds its value. While flag_ld is low both flags hold their values.
- R7: res_bus always shows the current ALU result. res_bus_en follows res_oe in the same cycle.
- R8: When flag_ld is high, the equal flag is loaded with 1 if the W-bit result is zero and with 0 otherwise.
- R9: op_sel = 7 passes A through unchanged, with carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | ALU operation code |
| alu_cin | input | 1 | Carry-in, supplied by the control store |
| acc_ld | input | 1 | Load the ALU result into the accumulator |
| flag_ld | input | 1 | Load the carry and equal flags |
| res_oe | input | 1 | Enable driving the result onto the data bus |
| bus_b | input | W | Data bus value, used as operand B |
| res_bus | output | W | ALU result, for driving onto the data bus |
| res_bus_en | output | 1 | Bus drive enable for res_bus |
| acc_q | output | W | Accumulator contents |
| carry_q | output | 1 | Stored carry flag |
| equal_q | output | 1 | Stored equal flag |

## Verification
A corrupted accumulator shows up at once on acc_q. Because the accumulator is operand A, the same fault also shows on res_bus in the very next operation that reads it, before any clock edge. A flag that was loaded wrongly, or that failed to hold, appears on carry_q or equal_q one edge after the load. To catch a leak from the stored carry into the adder, the bench sets the carry flag first and then adds with alu_cin low. It also preloads A for every vector through a pass-B load, so a fault in operand selection shows up in the result of the very next cycle.

// File: rtl/nib_pkg.sv
package nib_pkg;
  typedef enum logic [2:0] {
    OP_PASS_B = 3'd0,
    OP_ADD    = 3'd1,
    OP_SUB    = 3'd2,
    OP_AND    = 3'd3,
    OP_OR     = 3'd4,
    OP_XOR    = 3'd5,
    OP_NOT_A  = 3'd6,
    OP_PASS_A = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic carry;
    logic equal;
  } flags_t;
endpackage

// File: rtl/nib_alu.sv
module nib_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  nib_pkg::alu_op_e op_i,
  input  logic             cin_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);
  localparam int SW = W + 1;

  logic [W-1:0]  b_eff;
  logic [SW-1:0] sum;

  // The subtract path inverts B. Carry-in is whatever the control store gives.
  assign b_eff = (op_i == nib_pkg::OP_SUB) ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{(SW-1){1'b0}}, cin_i};

  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    unique case (op_i)
      nib_pkg::OP_PASS_B: res_o = b_i;
      nib_pkg::OP_ADD,
      nib_pkg::OP_SUB: begin
        res_o  = sum[W-1:0];
        cout_o = sum[W];
      end
      nib_pkg::OP_AND:    res_o = a_i & b_i;
      nib_pkg::OP_OR:     res_o = a_i | b_i;
      nib_pkg::OP_XOR:    res_o = a_i ^ b_i;
      nib_pkg::OP_NOT_A:  res_o = ~a_i;
      nib_pkg::OP_PASS_A: res_o = a_i;
      default:            res_o = '0;
    endcase
  end
endmodule

// File: rtl/nib_acc_reg.sv
module nib_acc_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/nib_flag_reg.sv
module nib_flag_reg #(
  parameter int W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_i,
  input  logic [W-1:0]    res_i,
  input  logic            cout_i,
  output nib_pkg::flags_t q_o
);
  nib_pkg::flags_t nxt;

  always_comb begin
    nxt.carry = cout_i;
    nxt.equal = (res_i == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (ld_i) q_o <= nxt;
  end
endmodule

// File: rtl/nib_alu_dp.sv
module nib_alu_dp #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_sel,
  input  logic         alu_cin,
  input  logic         acc_ld,
  input  logic         flag_ld,
  input  logic         res_oe,
  input  logic [W-1:0] bus_b,
  output logic [W-1:0] res_bus,
  output logic         res_bus_en,
  output logic [W-1:0] acc_q,
  output logic         carry_q,
  output logic         equal_q
);
  logic [W-1:0]    alu_res;
  logic            alu_cout;
  nib_pkg::flags_t flags;

  nib_alu #(.W(W)) u_alu (
    .a_i    (acc_q),
    .b_i    (bus_b),
    .op_i   (nib_pkg::alu_op_e'(op_sel)),
    .cin_i  (alu_cin),
    .res_o  (alu_res),
    .cout_o (alu_cout)
  );

  nib_acc_reg #(.W(W)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .ld_i (acc_ld),
    .d_i  (alu_res),
    .q_o  (acc_q)
  );

  nib_flag_reg #(.W(W)) u_flg (
    .clk    (clk),
    .rst    (rst),
    .ld_i   (flag_ld),
    .res_i  (alu_res),
    .cout_i (alu_cout),
    .q_o    (flags)
  );

  assign res_bus    = alu_res;
  assign res_bus_en = res_oe;
  assign carry_q    = flags.carry;
  assign equal_q    = flags.equal;
endmodule

// File: rtl/nib_dp_chk.sv
module nib_dp_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op_sel,
  input logic         alu_cin,
  input logic         acc_ld,
  input logic         flag_ld,
  input logic [W-1:0] bus_b,
  input logic [W-1:0] res_bus,
  input logic [W-1:0] acc_q,
  input logic         carry_q,
  input logic         equal_q
);
  logic [W-1:0] add_ref;
  logic         rst_seen;

  assign add_ref = acc_q + bus_b + {{(W-1){1'b0}}, alu_cin};

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: state is clear one edge after reset is sampled high
  always_ff @(posedge clk) begin
    if (rst_seen === 1'b1)
      p_reset_clear_r1: assert (acc_q == '0 && !carry_q && !equal_q)
        else $error("R1 reset state");
  end

  // R4: the adder result depends only on A, B and alu_cin
  always_comb begin
    if (rst === 1'b0 && op_sel == 3'd1)
      p_cin_only_r4: assert (res_bus == add_ref) else $error("R4 carry leak");
  end

  p_add_load_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_ld && op_sel == 3'd1) |=> acc_q == $past(add_ref));

  p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !acc_ld |=> $stable(acc_q));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !flag_ld |=> ($stable(carry_q) && $stable(equal_q)));

  p_equal_zero_r8: assert property (@(posedge clk) disable iff (rst)
    flag_ld |=> equal_q == ($past(res_bus) == '0));

  p_logic_nocarry_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_ld && op_sel != 3'd1 && op_sel != 3'd2) |=> !carry_q);
endmodule

bind nib_alu_dp nib_dp_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_sel  (op_sel),
  .alu_cin (alu_cin),
  .acc_ld  (acc_ld),
  .flag_ld (flag_ld),
  .bus_b   (bus_b),
  .res_bus (res_bus),
  .acc_q   (acc_q),
  .carry_q (carry_q),
  .equal_q (equal_q)
);

// File: tb/sim_nib_alu_dp.sv
module sim_nib_alu_dp;
  localparam int W  = 4;
  localparam int NV = 13;
  // {op[2:0], cin, a[3:0], b[3:0], res[3:0], carry, equal}
  localparam logic [17:0] VEC [NV] = '{
    {3'd1, 1'b0, 4'h3, 4'h4, 4'h7, 1'b0, 1'b0},
    {3'd1, 1'b0, 4'hF, 4'h1, 4'h0, 1'b1, 1'b1},
    {3'd1, 1'b1, 4'h7, 4'h8, 4'h0, 1'b1, 1'b1},
    {3'd2, 1'b1, 4'h9, 4'h9, 4'h0, 1'b1, 1'b1},
    {3'd2, 1'b1, 4'h5, 4'h9, 4'hC, 1'b0, 1'b0},
    {3'd2, 1'b1, 4'hA, 4'h3, 4'h7, 1'b1, 1'b0},
    {3'd3, 1'b0, 4'hC, 4'hA, 4'h8, 1'b0, 1'b0},
    {3'd4, 1'b0, 4'hC, 4'h3, 4'hF, 1'b0, 1'b0},
    {3'd5, 1'b0, 4'h5, 4'h5, 4'h0, 1'b0, 1'b1},
    {3'd6, 1'b0, 4'h6, 4'h0, 4'h9, 1'b0, 1'b0},
    {3'd0, 1'b0, 4'h2, 4'h0, 4'h0, 1'b0, 1'b1},
    {3'd7, 1'b0, 4'hB, 4'h4, 4'hB, 1'b0, 1'b0},
    {3'd1, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst, alu_cin, acc_ld, flag_ld, res_oe;
  logic [2:0] op_sel;
  logic [W-1:0] bus_b, res_bus, acc_q;
  logic res_bus_en, carry_q, equal_q;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nib_alu_dp #(.W(W)) u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .alu_cin(alu_cin),
    .acc_ld(acc_ld), .flag_ld(flag_ld), .res_oe(res_oe), .bus_b(bus_b),
    .res_bus(res_bus), .res_bus_en(res_bus_en), .acc_q(acc_q),
    .carry_q(carry_q), .equal_q(equal_q)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, registers updated after next posedge
  task automatic cyc(input logic [2:0] op, input logic ci, input logic [W-1:0] b,
                     input logic al, input logic fl);
    @(negedge clk);
    op_sel = op; alu_cin = ci; bus_b = b; acc_ld = al; flag_ld = fl;
    @(posedge clk);
    #1;
    acc_ld = 1'b0; flag_ld = 1'b0;
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd7:    return "R9";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_sel = 3'd0; alu_cin = 1'b0; acc_ld = 1'b0;
    flag_ld = 1'b0; res_oe = 1'b0; bus_b = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", {4'h0, acc_q}, 8'h00);
    check("R1", {6'h0, carry_q, equal_q}, 8'h00);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic ci; logic [3:0] a, b, r; logic c, e;
      {op, ci, a, b, r, c, e} = VEC[i];
      cyc(3'd0, 1'b0, a, 1'b1, 1'b0);          // preload A via pass B
      @(negedge clk);
      op_sel = op; alu_cin = ci; bus_b = b; acc_ld = 1'b1; flag_ld = 1'b1;
      #1;
      check(req_of(op), {4'h0, res_bus}, {4'h0, r});   // R7 combinational result
      @(posedge clk); #1;
      acc_ld = 1'b0; flag_ld = 1'b0;
      check(req_of(op), {4'h0, acc_q}, {4'h0, r});
      check("R8", {6'h0, carry_q, equal_q}, {6'h0, c, e});
    end

    // R6: holds with loads low; set flags to carry=1, equal=1 first
    cyc(3'd0, 1'b0, 4'hF, 1'b1, 1'b0);
    cyc(3'd1, 1'b0, 4'h1, 1'b1, 1'b1);       // acc=0, c=1, e=1
    cyc(3'd0, 1'b0, 4'h6, 1'b0, 1'b0);       // would load 6 and clear flags
    check("R6", {4'h0, acc_q}, 8'h00);
    check("R6", {6'h0, carry_q, equal_q}, 8'h03);

    // R4: stored carry=1 must not add into the sum
    cyc(3'd0, 1'b0, 4'h2, 1'b1, 1'b0);
    check("R4", {6'h0, carry_q, equal_q}, 8'h03);
    @(negedge clk);
    op_sel = 3'd1; alu_cin = 1'b0; bus_b = 4'h3;
    #1;
    check("R4", {4'h0, res_bus}, 8'h05);

    // R3: compare leaves accumulator alone, flags show A<B
    cyc(3'd2, 1'b1, 4'h4, 1'b0, 1'b1);
    check("R3", {4'h0, acc_q}, 8'h02);
    check("R3", {6'h0, carry_q, equal_q}, 8'h00);

    // R7: drive enable follows res_oe
    @(negedge clk); res_oe = 1'b1; #1;
    check("R7", {7'h0, res_bus_en}, 8'h01);
    @(negedge clk); res_oe = 1'b0; #1;
    check("R7", {7'h0, res_bus_en}, 8'h00);

    // R1: mid-run reset clears nonzero state
    cyc(3'd1, 1'b1, 4'hF, 1'b1, 1'b1);        // 2+F+1 -> 2, carry 1
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1", {4'h0, acc_q}, 8'h00);
    check("R1", {6'h0, carry_q, equal_q}, 8'h00);
    @(negedge clk); rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule